// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Controller

This block holds the digital state behind a two-channel digital-to-analog converter. It accepts an already decoded command, made of a 4-bit operation code and a 10-bit sample value, qualified by a one-cycle valid strobe. Each channel has two registers. The staging register takes new sample values. The live register holds the value that the converter sees. The block also keeps a power state, either awake or asleep.

A single command can do several things in the same cycle: stage a value, move both staged values into the live registers, and set the power state. The two live registers always change together and never one at a time. Values can be staged while the block is asleep. While asleep, the output-enable is low, which tells the analog side to present high impedance. The sleep status is also driven as its own output.

Top module: `dac_dual_regctl`

## Requirements
- R1: After reset, all four registers read zero, the block is awake, `out_en` is 1 and `asleep` is 0.
- R2: Operation code 4'b0000, and every code not listed in R3 to R7, changes no register and leaves the power state unchanged.
- R3: Code 4'b0001 loads staging A and code 4'b0010 loads staging B with `cmd_data`. Neither code changes the live registers or the power state, and both work while asleep.
- R4: Code 4'b1000 copies both staging registers into both live registers and wakes the block.
- R5: Code 4'b1001 loads staging A and then updates both live registers from the new A and the existing B, and wakes the block. Code 4'b1010 does the same with the roles of A and B swapped.
- R6: Code 4'b1111 loads `cmd_data` into both staging registers, updates both live registers with it, and wakes the block.
- R7: Code 4'b1101 wakes the block and code 4'b1110 puts it to sleep. Neither code changes any register.
- R8: `out_en` always equals the inverse of `asleep`, and every command takes effect on the clock edge where `cmd_valid` is sampled high. With `cmd_valid` low, nothing changes.
- R9: The two live registers only change on the same edge as each other, and only on an edge that also leaves the block awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Operation code |
| cmd_data | input | 10 | Sample value |
| stage_a | output | 10 | Staging register A |
| stage_b | output | 10 | Staging register B |
| live_a | output | 10 | Live code for channel A |
| live_b | output | 10 | Live code for channel B |
| out_en | output | 1 | Output drive enable (low means high impedance) |
| asleep | output | 1 | Power state, 1 while asleep |

## Verification
The assertions check two things on every cycle. The first is that `out_en` and `asleep` stay complementary. The second is that a live update always leaves the block awake and always carries the staging contents in. The assertions also check that an idle cycle freezes all state, and that sleeping or wakeup-only commands leave the registers alone. Whether each specific code selects the right register with the right value can only be shown by the bench's directed scenarios. This covers staging during sleep, the mixed new/old transfer of the combined codes, and undefined codes acting as no-ops.

// File: rtl/dac_dual_regctl.sv
module dac_dual_regctl #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [3:0]   cmd_op,
  input  logic [W-1:0] cmd_data,
  output logic [W-1:0] stage_a,
  output logic [W-1:0] stage_b,
  output logic [W-1:0] live_a,
  output logic [W-1:0] live_b,
  output logic         out_en,
  output logic         asleep
);

  logic ld_a, ld_b, xfer, wake, sleep_req;
  logic [W-1:0] nxt_a, nxt_b;

  always_comb begin
    ld_a = 1'b0; ld_b = 1'b0; xfer = 1'b0; wake = 1'b0; sleep_req = 1'b0;
    if (cmd_valid) begin
      unique case (cmd_op)
        4'b0001: ld_a = 1'b1;
        4'b0010: ld_b = 1'b1;
        4'b1000: begin xfer = 1'b1; wake = 1'b1; end
        4'b1001: begin ld_a = 1'b1; xfer = 1'b1; wake = 1'b1; end
        4'b1010: begin ld_b = 1'b1; xfer = 1'b1; wake = 1'b1; end
        4'b1101: wake = 1'b1;
        4'b1110: sleep_req = 1'b1;
        4'b1111: begin ld_a = 1'b1; ld_b = 1'b1; xfer = 1'b1; wake = 1'b1; end
        default: ;
      endcase
    end
  end

  assign nxt_a = ld_a ? cmd_data : stage_a;
  assign nxt_b = ld_b ? cmd_data : stage_b;
  assign out_en = ~asleep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_a <= '0; stage_b <= '0; live_a <= '0; live_b <= '0; asleep <= 1'b0;
    end else begin
      stage_a <= nxt_a;
      stage_b <= nxt_b;
      if (xfer) begin
        live_a <= nxt_a;
        live_b <= nxt_b;
      end
      if (wake) asleep <= 1'b0;
      else if (sleep_req) asleep <= 1'b1;
    end
  end

  assert_oe_inverse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_en == !asleep);

  assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(stage_a) && $stable(stage_b) && $stable(live_a)
                   && $stable(live_b) && $stable(asleep));

  assert_update_awake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(live_a) || !$stable(live_b)) |-> !asleep
      && live_a == stage_a && live_b == stage_b);

  assert_power_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 4'b1101 || cmd_op == 4'b1110)) |=>
      $stable(stage_a) && $stable(stage_b) && $stable(live_a) && $stable(live_b));

  assert_sleep_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 4'b1110) |=> asleep);

  assert_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 4'b0000) |=> $stable(asleep) && $stable(live_a)
      && $stable(stage_a) && $stable(stage_b));

endmodule

// File: tb/dac_dual_regctl_tb.sv
module dac_dual_regctl_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [9:0] cmd_data = '0;
  logic [9:0] stage_a, stage_b, live_a, live_b;
  logic out_en, asleep;
  int checks = 0, errors = 0;
  logic [9:0] ea = 0, eb = 0, la = 0, lb = 0;
  logic es = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_dual_regctl u_dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .stage_a(stage_a), .stage_b(stage_b), .live_a(live_a),
    .live_b(live_b), .out_en(out_en), .asleep(asleep));

  task automatic chk(string req);
    checks++;
    if ({stage_a, stage_b, live_a, live_b, asleep, out_en} !== {ea, eb, la, lb, es, ~es}) begin
      errors++;
      $display("FAIL %s: got sa=%0d sb=%0d la=%0d lb=%0d sl=%0b oe=%0b exp sa=%0d sb=%0d la=%0d lb=%0d sl=%0b oe=%0b",
        req, stage_a, stage_b, live_a, live_b, asleep, out_en, ea, eb, la, lb, es, ~es);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input logic [9:0] d, input logic v = 1'b1);
    @(negedge clk); cmd_valid = v; cmd_op = op; cmd_data = d;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1");
  endtask

  task automatic t_stage;
    cmd(4'b0001, 10'd300); ea = 300; chk("R3");
    cmd(4'b0010, 10'd1023); eb = 1023; chk("R3");
  endtask

  task automatic t_xfer;
    cmd(4'b1000, 10'd5); la = ea; lb = eb; chk("R4");
  endtask

  task automatic t_sleep_stage;
    cmd(4'b1110, 10'd77); es = 1; chk("R7");
    cmd(4'b0001, 10'd12); ea = 12; chk("R3");
    cmd(4'b1010, 10'd600); eb = 600; la = 12; lb = 600; es = 0; chk("R5");
    cmd(4'b0010, 10'd44); eb = 44; chk("R3");
    cmd(4'b1001, 10'd9); ea = 9; la = 9; lb = 44; chk("R5");
  endtask

  task automatic t_power;
    cmd(4'b1110, 10'd1); es = 1; chk("R7");
    cmd(4'b1101, 10'd2); es = 0; chk("R7");
    cmd(4'b1110, 10'd3); es = 1; chk("R7");
    cmd(4'b1000, 10'd4); es = 0; chk("R4");
  endtask

  task automatic t_nop;
    cmd(4'b1110, 10'd0); es = 1; chk("R7");
    cmd(4'b0000, 10'd888); chk("R2");
    foreach (ops[i]) begin cmd(ops[i], 10'd555); chk("R2"); end
    cmd(4'b1111, 10'd555, 1'b0); chk("R8");
  endtask
  logic [3:0] ops [7] = '{4'b0011, 4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1011, 4'b1100};

  task automatic t_both;
    cmd(4'b1111, 10'd513); ea = 513; eb = 513; la = 513; lb = 513; es = 0; chk("R6");
    cmd(4'b1111, 10'd0); ea = 0; eb = 0; la = 0; lb = 0; chk("R6");
  endtask

  task automatic t_midreset;
    cmd(4'b1110, 10'd0); es = 1; chk("R7");
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    ea = 0; eb = 0; la = 0; lb = 0; es = 0; chk("R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_stage; t_xfer; t_sleep_stage; t_power; t_nop; t_both;
    cmd(4'b0001, 10'd100); ea = 100; chk("R3");
    t_midreset;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule